// File: doc/BRIEF.md
# JTAG debug register access unit

This unit gives an external debugger access to a small bank of on-chip debug registers through a standard four-wire test port. A TAP controller is clocked by `tck` and steered by `tms`. Every instruction-path scan loads a 10-bit command. That command holds a 7-bit register select and a read flag. The data-path scan that follows exchanges 32 bits with the selected register. The old contents come out on `tdo` while the new value goes in on `tdi`. The new value is committed at Update-DR only when the command asked for a write.

Two select codes turn the data path into a one-bit bypass flop, and one of them also raises a debug-enable flag. Control register 0 carries an external-debug-mode bit. While that bit is clear, only control register 0 itself can be read or written: every other register reads as zero and ignores writes. A read-only program-counter history value comes in from outside. A small range of select codes is invalid and leaves the whole bank untouched. Either a synchronous reset or five `tms`-high clocks returns the TAP to Test-Logic-Reset, which clears the debug-mode bit and the enable flag.

Top module: `dbg_tap_access`

## Requirements
- R1: The TAP enters Test-Logic-Reset in either of two ways: `tap_rst` high at a `tck` edge, or five consecutive `tms`-high clocks. In that state the command returns to bypass-with-read (select 0x7F, read flag 1), `ext_dbg_mode` and `dbg_enable` clear, and `tdo` is 0.
- R2: The command is 10 bits shifted LSB first: select in bits 6:0, two ignored bits 8:7, read flag in bit 9 (1 = read, 0 = write). Capture-IR loads 10'b00_0000_0001, so that pattern shifts out. The command changes only at Update-IR or in Test-Logic-Reset.
- R3: With select 0x7F the data path is one flop that captures 0. Shifted-out data is therefore a 0 followed by `tdi` delayed by one clock.
- R4: Select 0x7E acts as bypass. Its Update-IR also sets `dbg_enable`, which stays set until Test-Logic-Reset.
- R5: Select 0x31 is control register 0 and is always readable and writable. Its bit 31 is the external-debug-mode bit, driven on `ext_dbg_mode`.
- R6: While the debug-mode bit is 0, a data scan to any select other than 0x31 shifts out zeros and its write is ignored.
- R7: With the debug-mode bit set, selects 0x70 to 0x79 address ten 32-bit general registers that hold what was written. Data shifts LSB first.
- R8: Select 0x2D shifts out the `pc_hist` input captured at Capture-DR. A write to it changes nothing.
- R9: Selects 0x38 to 0x3C are invalid. They shift out zeros and a write to them alters no register.
- R10: A data scan with the read flag set commits nothing, whatever is shifted in.
- R11: With the debug-mode bit set, select 0x30 is a 32-bit status register that reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| tap_rst | input | 1 | Synchronous active-high TAP reset |
| tms | input | 1 | Test mode select, steers the TAP state machine |
| tdi | input | 1 | Serial data in, LSB first |
| pc_hist | input | 32 | Program-counter history value, read-only through select 0x2D |
| tdo | output | 1 | Serial data out; 0 outside the shift states |
| dbg_enable | output | 1 | Set by an Update-IR with select 0x7E |
| ext_dbg_mode | output | 1 | External-debug-mode bit (control register 0 bit 31) |

## Verification
Most internal faults stay hidden until the next data scan to the affected register. That scan shows them in its first 32 `tdo` bits. The one exception is a corrupted debug-mode bit, which shows on `ext_dbg_mode` one clock after the faulty Update-DR. A stray commit to a register caused by an invalid select, a read, or a gated write shows up only when that register is read back later, so the vector table reads every victim register back after each such access. A wrong TAP transition moves the shift window, and the shifted-out bits then come out offset or as the capture pattern of the wrong path.

// File: rtl/dbgacc_pkg.sv
package dbgacc_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned SEL_W  = 7;
    localparam int unsigned IR_W   = 10;

    localparam logic [SEL_W-1:0] SEL_PCHIST   = 7'h2D;
    localparam logic [SEL_W-1:0] SEL_STAT     = 7'h30;
    localparam logic [SEL_W-1:0] SEL_CTRL0    = 7'h31;
    localparam logic [SEL_W-1:0] SEL_GPR_BASE = 7'h70;
    localparam logic [SEL_W-1:0] SEL_ENBYP    = 7'h7E;
    localparam logic [SEL_W-1:0] SEL_BYPASS   = 7'h7F;

    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        K_BYPASS, K_CTRL0, K_STAT, K_PCHIST, K_GPR, K_EMPTY
    } sel_kind_e;

    typedef struct packed {
        logic             rd;
        logic [SEL_W-1:0] sel;
    } cmd_t;

    localparam cmd_t CMD_RESET = '{rd: 1'b1, sel: SEL_BYPASS};

    function automatic sel_kind_e classify(input logic [SEL_W-1:0] sel, input int ngpr);
        if (sel == SEL_BYPASS || sel == SEL_ENBYP) return K_BYPASS;
        if (sel == SEL_CTRL0)  return K_CTRL0;
        if (sel == SEL_STAT)   return K_STAT;
        if (sel == SEL_PCHIST) return K_PCHIST;
        if (int'(sel) >= int'(SEL_GPR_BASE) && int'(sel) < int'(SEL_GPR_BASE) + ngpr)
            return K_GPR;
        return K_EMPTY;
    endfunction

endpackage

// File: rtl/dbgacc_tap_fsm.sv
module dbgacc_tap_fsm
    import dbgacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    always_comb begin
        case (state)
            TLR:     nxt = tms ? TLR    : RTI;
            RTI:     nxt = tms ? SEL_DR : RTI;
            SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
            CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
            SH_DR:   nxt = tms ? EX1_DR : SH_DR;
            EX1_DR:  nxt = tms ? UPD_DR : PAU_DR;
            PAU_DR:  nxt = tms ? EX2_DR : PAU_DR;
            EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
            UPD_DR:  nxt = tms ? SEL_DR : RTI;
            SEL_IR:  nxt = tms ? TLR    : CAP_IR;
            CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
            SH_IR:   nxt = tms ? EX1_IR : SH_IR;
            EX1_IR:  nxt = tms ? UPD_IR : PAU_IR;
            PAU_IR:  nxt = tms ? EX2_IR : PAU_IR;
            EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
            UPD_IR:  nxt = tms ? SEL_DR : RTI;
            default: nxt = TLR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TLR;
        else     state <= nxt;
    end

    // R1
    tap_reset_chk: assert property (@(posedge clk) rst |=> state == TLR);

    // R1
    five_tms_chk: assert property (@(posedge clk) disable iff (rst)
        tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)
        |=> state == TLR);

endmodule

// File: rtl/dbgacc_cmd_reg.sv
module dbgacc_cmd_reg
    import dbgacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output cmd_t       cmd,
    output logic       ir_tdo,
    output logic       dbg_en
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge clk) begin
        if (rst || state == TLR) begin
            ir_sh  <= '0;
            cmd    <= CMD_RESET;
            dbg_en <= 1'b0;
        end else begin
            case (state)
                CAP_IR: ir_sh <= IR_W'(1);
                SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                UPD_IR: begin
                    cmd <= '{rd: ir_sh[IR_W-1], sel: ir_sh[SEL_W-1:0]};
                    if (ir_sh[SEL_W-1:0] == SEL_ENBYP) dbg_en <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ir_tdo = ir_sh[0];

    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        state != UPD_IR && state != TLR |=> $stable(cmd));

    // R4
    dbg_en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_en) |-> $past(state) == UPD_IR && cmd.sel == SEL_ENBYP);

endmodule

// File: rtl/dbgacc_dr_bank.sv
module dbgacc_dr_bank
    import dbgacc_pkg::*;
#(
    parameter int NUM_GPR = 10,
    parameter int EDM_BIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_state_e        state,
    input  logic              tdi,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] pc_hist,
    output logic              dr_tdo,
    output logic              edm
);

    localparam int GIDX_W = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1;

    logic [NUM_GPR-1:0][DATA_W-1:0] gpr;
    logic [DATA_W-1:0] ctrl0, stat, dr_sh, rd_val;
    logic              byp;
    sel_kind_e         kind;
    logic [GIDX_W-1:0] gidx;
    logic              allow, wr;

    assign kind  = classify(cmd.sel, NUM_GPR);
    assign gidx  = GIDX_W'(cmd.sel - SEL_GPR_BASE);
    assign edm   = ctrl0[EDM_BIT];
    assign allow = (kind == K_CTRL0) || edm;
    assign wr    = (state == UPD_DR) && !cmd.rd && allow;

    always_comb begin
        rd_val = '0;
        if (allow) begin
            case (kind)
                K_CTRL0:  rd_val = ctrl0;
                K_STAT:   rd_val = stat;
                K_PCHIST: rd_val = pc_hist;
                K_GPR:    rd_val = gpr[gidx];
                default:  rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gpr   <= '0;
            ctrl0 <= '0;
            stat  <= '0;
            dr_sh <= '0;
            byp   <= 1'b0;
        end else begin
            if (state == TLR) ctrl0 <= '0;
            case (state)
                CAP_DR: begin
                    dr_sh <= rd_val;
                    byp   <= 1'b0;
                end
                SH_DR: begin
                    dr_sh <= {tdi, dr_sh[DATA_W-1:1]};
                    byp   <= tdi;
                end
                UPD_DR: if (wr) begin
                    case (kind)
                        K_CTRL0: ctrl0     <= dr_sh;
                        K_STAT:  stat      <= dr_sh;
                        K_GPR:   gpr[gidx] <= dr_sh;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign dr_tdo = (kind == K_BYPASS) ? byp : dr_sh[0];

    // R1
    tlr_clears_edm_chk: assert property (@(posedge clk) disable iff (rst)
        state == TLR |=> !edm);

    // R6
    edm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        state == UPD_DR && !edm && kind != K_CTRL0 |=> $stable(gpr) && $stable(stat));

    // R9
    empty_sel_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        state == UPD_DR && kind == K_EMPTY |=> $stable(gpr) && $stable(stat) && $stable(ctrl0));

    // R10
    read_nocommit_chk: assert property (@(posedge clk) disable iff (rst)
        state == UPD_DR && cmd.rd |=> $stable(gpr) && $stable(stat) && $stable(ctrl0));

endmodule

// File: rtl/dbg_tap_access.sv
module dbg_tap_access
    import dbgacc_pkg::*;
#(
    parameter int NUM_GPR = 10,
    parameter int EDM_BIT = 31
) (
    input  logic              tck,
    input  logic              tap_rst,
    input  logic              tms,
    input  logic              tdi,
    input  logic [DATA_W-1:0] pc_hist,
    output logic              tdo,
    output logic              dbg_enable,
    output logic              ext_dbg_mode
);

    tap_state_e state;
    cmd_t       cmd;
    logic       ir_tdo, dr_tdo;

    dbgacc_tap_fsm u_fsm (
        .clk   (tck),
        .rst   (tap_rst),
        .tms   (tms),
        .state (state)
    );

    dbgacc_cmd_reg u_cmd (
        .clk    (tck),
        .rst    (tap_rst),
        .state  (state),
        .tdi    (tdi),
        .cmd    (cmd),
        .ir_tdo (ir_tdo),
        .dbg_en (dbg_enable)
    );

    dbgacc_dr_bank #(.NUM_GPR(NUM_GPR), .EDM_BIT(EDM_BIT)) u_bank (
        .clk     (tck),
        .rst     (tap_rst),
        .state   (state),
        .tdi     (tdi),
        .cmd     (cmd),
        .pc_hist (pc_hist),
        .dr_tdo  (dr_tdo),
        .edm     (ext_dbg_mode)
    );

    always_comb begin
        if (state == SH_IR)      tdo = ir_tdo;
        else if (state == SH_DR) tdo = dr_tdo;
        else                     tdo = 1'b0;
    end

endmodule

// File: tb/tb_dbg_tap_access.sv
`timescale 1ns/1ps
module tb_dbg_tap_access;

    localparam logic [31:0] PC_VAL = 32'h0040_1A2C;
    localparam int NV = 20;

    typedef struct packed {
        logic [6:0]  sel;
        logic        rd;
        logic [31:0] wd;
        logic [31:0] ex;
        logic [3:0]  req;
    } vec_t;

    // Each vector: command select, read flag (1 = read), data shifted in, data expected out.
    localparam vec_t VEC [NV] = '{
        '{7'h70, 1'b0, 32'h1111_1111, 32'h0000_0000, 4'd6},  // R6 gated write
        '{7'h70, 1'b1, 32'h0000_0000, 32'h0000_0000, 4'd6},  // R6 gated read
        '{7'h31, 1'b0, 32'h8000_0005, 32'h0000_0000, 4'd5},  // R5 set mode bit
        '{7'h31, 1'b1, 32'h0000_0000, 32'h8000_0005, 4'd5},  // R5 read back
        '{7'h70, 1'b0, 32'hA5A5_0001, 32'h0000_0000, 4'd7},  // R7 first gpr
        '{7'h79, 1'b0, 32'h1234_5678, 32'h0000_0000, 4'd7},  // R7 last gpr
        '{7'h70, 1'b1, 32'hFFFF_FFFF, 32'hA5A5_0001, 4'd10}, // R10 read with ones in
        '{7'h70, 1'b1, 32'h0000_0000, 32'hA5A5_0001, 4'd10}, // R10 unchanged
        '{7'h3A, 1'b0, 32'hDEAD_BEEF, 32'h0000_0000, 4'd9},  // R9 invalid write
        '{7'h70, 1'b1, 32'h0000_0000, 32'hA5A5_0001, 4'd9},  // R9 no alteration
        '{7'h30, 1'b0, 32'h0000_00F0, 32'h0000_0000, 4'd11}, // R11 status write
        '{7'h30, 1'b1, 32'h0000_0000, 32'h0000_00F0, 4'd11}, // R11 status read
        '{7'h2D, 1'b0, 32'h0000_0000, PC_VAL,        4'd8},  // R8 write ignored
        '{7'h2D, 1'b1, 32'h0000_0000, PC_VAL,        4'd8},  // R8 read
        '{7'h79, 1'b1, 32'h0000_0000, 32'h1234_5678, 4'd7},  // R7 last gpr read
        '{7'h31, 1'b0, 32'h0000_0000, 32'h8000_0005, 4'd5},  // R5 clear mode bit
        '{7'h79, 1'b1, 32'h0000_0000, 32'h0000_0000, 4'd6},  // R6 read gated
        '{7'h79, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd6},  // R6 write gated
        '{7'h31, 1'b0, 32'h8000_0000, 32'h0000_0000, 4'd5},  // R5 set mode again
        '{7'h79, 1'b1, 32'h0000_0000, 32'h1234_5678, 4'd6}   // R6 earlier write was ignored
    };

    logic tck = 1'b0, tap_rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo, dbg_enable, ext_dbg_mode;
    int   n_chk = 0, n_bad = 0;

    always #2 tck = ~tck;

    dbg_tap_access dut (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .pc_hist(PC_VAL),
        .tdo(tdo), .dbg_enable(dbg_enable), .ext_dbg_mode(ext_dbg_mode)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m; tdi = d;
        #0.5 o = tdo;
    endtask

    task automatic ir_scan(input logic [9:0] c, output logic [9:0] o);
        logic x;
        tick(1, 0, x); tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
        for (int i = 0; i < 10; i++) tick(i == 9, c[i], o[i]);
        tick(1, 0, x); tick(0, 0, x);
    endtask

    task automatic dr_scan(input int n, input logic [31:0] d, output logic [31:0] o);
        logic x;
        o = '0;
        tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
        for (int i = 0; i < n; i++) tick(i == n - 1, d[i], o[i]);
        tick(1, 0, x); tick(0, 0, x);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge tck);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [9:0]  io;
        logic [31:0] dout;
        logic        x;

        repeat (3) @(posedge tck);
        @(negedge tck) tap_rst = 1'b0;
        #0.5;
        // R1 reset state
        check(tdo == 0 && dbg_enable == 0 && ext_dbg_mode == 0, "R1 reset outputs",
              {29'd0, tdo, dbg_enable, ext_dbg_mode}, 32'd0);
        tick(0, 0, x);

        // R1 R3: command is bypass after reset, one-flop path capturing 0
        dr_scan(8, 32'hB4, dout);
        check(dout[7:0] == 8'h68, "R3 bypass after reset", dout, 32'h68);

        // R2: capture pattern and load of bypass command
        ir_scan(10'h27F, io);
        check(io == 10'h001, "R2 IR capture pattern", {22'd0, io}, 32'h001);

        for (int v = 0; v < NV; v++) begin
            ir_scan({VEC[v].rd, 2'b00, VEC[v].sel}, io);
            dr_scan(32, VEC[v].wd, dout);
            n_chk++;
            if (dout !== VEC[v].ex) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: got %h expected %h", VEC[v].req, v, dout, VEC[v].ex);
            end
        end

        // R5: mode bit set by the last control write
        tick(0, 0, x);
        check(ext_dbg_mode == 1, "R5 mode output", {31'd0, ext_dbg_mode}, 32'd1);

        // R4: enable-bypass command
        check(dbg_enable == 0, "R4 flag clear before", {31'd0, dbg_enable}, 32'd0);
        ir_scan(10'h27E, io);
        tick(0, 0, x);
        check(dbg_enable == 1, "R4 flag set", {31'd0, dbg_enable}, 32'd1);
        dr_scan(8, 32'h5A, dout);
        check(dout[7:0] == 8'hB4, "R4 bypass path", dout, 32'hB4);
        check(dbg_enable == 1, "R4 flag held", {31'd0, dbg_enable}, 32'd1);

        // R1: five tms-high clocks
        repeat (5) tick(1, 0, x);
        tick(0, 0, x);
        tick(0, 0, x);
        check(ext_dbg_mode == 0 && dbg_enable == 0, "R1 five tms clears",
              {30'd0, ext_dbg_mode, dbg_enable}, 32'd0);
        dr_scan(8, 32'hFF, dout);
        check(dout[7:0] == 8'hFE, "R1 command back to bypass", dout, 32'hFE);

        // R1: synchronous reset clears mode bit
        ir_scan({1'b0, 2'b00, 7'h31}, io);
        dr_scan(32, 32'h8000_0000, dout);
        tick(0, 0, x);
        check(ext_dbg_mode == 1, "R5 mode set again", {31'd0, ext_dbg_mode}, 32'd1);
        @(negedge tck) tap_rst = 1'b1; tms = 1'b1;
        repeat (2) @(negedge tck);
        tap_rst = 1'b0;
        #0.5;
        check(ext_dbg_mode == 0 && tdo == 0, "R1 reset pin clears",
              {30'd0, ext_dbg_mode, tdo}, 32'd0);

        summary();
        $finish;
    end

endmodule